// File: doc/BRIEF.md
# Supply and Push-Button Reset Generator

This block drives the active-low reset line of a processor from two sources. The first is a digital supply-good indication. While the supply is reported bad, the reset line is pulled low. After the supply recovers, the line stays low for a fixed stabilization interval and is then released. The second source is an active-low push-button input. That input has to stay low for a minimum number of sampled cycles to count. Once it counts, it produces a reset of the same length as a power-up reset, and the interval is timed from the moment the button is let go. The reset pin is open drain, so the block outputs a pull-down enable and never drives the line high.

The block also gates a power-fail warning output. While the system runs on its backup battery, the warning output is held low. When main power returns, the output is held high for the same recovery interval. After that it follows a comparator bit that reports whether the monitored rail is above its threshold. All four inputs are asynchronous to the block clock and pass through a synchronizer of `SYNC_STAGES` flops first. The analog comparators and the pull-up resistors sit outside the block.

Top module: `rstgen_top`

## Requirements
- R1: During and straight after the block reset, `rst_pull_o` is 1 (the reset line is pulled low) and `pfo_o` is 0.
- R2: When `supply_ok_i` goes low, `rst_pull_o` becomes 1 exactly SYNC_STAGES+1 clock cycles later. It stays 1 for as long as `supply_ok_i` is low.
- R3: After `supply_ok_i` rises, `rst_pull_o` returns to 0 exactly HOLD_CYC+SYNC_STAGES cycles later, as long as no other reset source is active.
- R4: A low pulse on `mr_n_i` that lasts at least MIN_W synchronized samples is a qualifying pulse. It holds `rst_pull_o` at 1, and `rst_pull_o` returns to 0 exactly HOLD_CYC+SYNC_STAGES+1 cycles after `mr_n_i` returns high. A pulse of exactly MIN_W samples qualifies.
- R5: A low pulse on `mr_n_i` shorter than MIN_W samples never sets `rst_pull_o`.
- R6: A qualifying pulse that ends while a stretch interval is running restarts the interval. Release then comes HOLD_CYC+SYNC_STAGES+1 cycles after the later pulse ends.
- R7: A non-qualifying pulse that falls inside a running stretch interval does not move the release cycle.
- R8: When `batt_on_i` (1 = running from the backup battery) goes high, `pfo_o` is 0 exactly SYNC_STAGES cycles later and stays 0 while on battery.
- R9: When `batt_on_i` falls, `pfo_o` is 1 from SYNC_STAGES cycles later. It then follows `pf_above_i` from HOLD_CYC+SYNC_STAGES cycles after the fall.
- R10: Outside battery mode and outside the hold window, `pfo_o` equals `pf_above_i` (0 = monitored rail below threshold), SYNC_STAGES cycles delayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | 1 when the supply is above the power-fail threshold |
| batt_on_i | input | 1 | 1 while memory is powered from the backup battery |
| mr_n_i | input | 1 | Active-low push-button reset request |
| pf_above_i | input | 1 | Power-fail comparator, 1 when the monitored rail is above threshold |
| rst_pull_o | output | 1 | Open-drain enable, 1 pulls the processor reset line low |
| pfo_o | output | 1 | Power-fail warning, 0 means failing power |

## Verification
The assertions assume that `rst_n` is applied before any input is trusted, and that every input reaches the logic only through the synchronizer. They relate signals only after those stages, so the glitch and metastability behaviour of the raw pins falls outside them. The directed stimulus changes each raw input only on the falling clock edge. It holds every level for whole cycles, so the sampled pulse width is known exactly, and it uses widths on both sides of the MIN_W limit. The stimulus never asserts battery mode while the supply is reported good, except in the one scenario that checks the warning output on its own.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [1:0] {
    PFM_BATT  = 2'd0,
    PFM_HOLD  = 2'd1,
    PFM_TRACK = 2'd2
  } pfo_mode_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstgen_width_filter.sv
module rstgen_width_filter #(
  parameter int MIN_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n,
  output logic held_o,
  output logic fire_o
);
  localparam int FW = $clog2(MIN_W + 1);
  localparam logic [FW-1:0] LIMIT = FW'(MIN_W);

  logic [FW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          armed;

  assign armed  = (cnt_q == LIMIT);
  assign held_o = armed & ~mr_n;
  assign fire_o = armed & mr_n;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (mr_n) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!armed) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r4_fire_needs_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> !$past(mr_n));
  a_r5_counter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mr_n) |-> cnt_q == '0);
endmodule

// File: rtl/rstgen_hold_timer.sv
module rstgen_hold_timer #(
  parameter int HOLD_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  a_r3_release_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == CW'(1) && !$past(load_i)));
  a_r6_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == LOAD_V);
endmodule

// File: rtl/rstgen_pfo_gate.sv
module rstgen_pfo_gate
  import rstgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic batt_i,
  input  logic hold_busy_i,
  input  logic pf_above_i,
  output logic pfo_o
);
  pfo_mode_e mode;

  always_comb begin
    if (batt_i)           mode = PFM_BATT;
    else if (hold_busy_i) mode = PFM_HOLD;
    else                  mode = PFM_TRACK;
  end

  always_comb begin
    unique case (mode)
      PFM_BATT:  pfo_o = 1'b0;
      PFM_HOLD:  pfo_o = 1'b1;
      default:   pfo_o = pf_above_i;
    endcase
  end

  a_r9_return_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(batt_i) |-> pfo_o);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_W       = 10,
  parameter int HOLD_CYC    = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic batt_on_i,
  input  logic mr_n_i,
  input  logic pf_above_i,
  output logic rst_pull_o,
  output logic pfo_o
);
  localparam int NSIG = 4;
  localparam int B_OK = 0, B_BATT = 1, B_MR = 2, B_PF = 3;
  localparam logic [NSIG-1:0] SAFE = 4'b0110;

  logic [NSIG-1:0] raw, syn;
  logic s_ok, s_batt, s_mr_n, s_pf;
  logic mr_held, mr_fire;
  logic rst_load, rst_busy;
  logic pfo_busy;

  assign raw[B_OK]   = supply_ok_i;
  assign raw[B_BATT] = batt_on_i;
  assign raw[B_MR]   = mr_n_i;
  assign raw[B_PF]   = pf_above_i;

  rstgen_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SAFE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign s_ok   = syn[B_OK];
  assign s_batt = syn[B_BATT];
  assign s_mr_n = syn[B_MR];
  assign s_pf   = syn[B_PF];

  rstgen_width_filter #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .mr_n(s_mr_n), .held_o(mr_held), .fire_o(mr_fire)
  );

  assign rst_load = ~s_ok | mr_held | mr_fire;

  rstgen_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(rst_load), .busy_o(rst_busy)
  );

  rstgen_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_pfo_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(s_batt), .busy_o(pfo_busy)
  );

  rstgen_pfo_gate u_gate (
    .clk(clk), .rst_n(rst_n), .batt_i(s_batt), .hold_busy_i(pfo_busy),
    .pf_above_i(s_pf), .pfo_o(pfo_o)
  );

  assign rst_pull_o = rst_busy;

  a_r2_supply_low_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ok |=> rst_pull_o);
  a_r3_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull_o) |-> $past(s_ok));
  a_r4_fire_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    mr_fire |=> rst_pull_o);
  a_r8_battery_low_and_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_batt) |=> (!pfo_o && pfo_busy));
endmodule

// File: tb/sim_rstgen_top.sv
module sim_rstgen_top;
  localparam int SYN = 2;
  localparam int W   = 4;
  localparam int S   = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, batt_on, mr_n, pf_above;
  logic rst_pull, pfo;
  int   total = 0;
  int   bad   = 0;

  always #10 clk = ~clk;

  rstgen_top #(.SYNC_STAGES(SYN), .MIN_W(W), .HOLD_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .batt_on_i(batt_on),
    .mr_n_i(mr_n), .pf_above_i(pf_above), .rst_pull_o(rst_pull), .pfo_o(pfo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Edges from now until rst_pull is seen high and then low again.
  task automatic wait_release(output int n);
    bit seen = 1'b0;
    n = 999;
    for (int i = 1; i <= 300; i++) begin
      step();
      if (rst_pull) seen = 1'b1;
      else if (seen) begin n = i; break; end
    end
  endtask

  task automatic mr_pulse(input int len);
    mr_n = 1'b0;
    repeat (len) step();
    mr_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_ok = 1'b0; batt_on = 1'b1; mr_n = 1'b1; pf_above = 1'b0;
    repeat (3) step();
    chk(rst_pull == 1'b1, "R1 rst_pull in reset", rst_pull, 1);
    chk(pfo == 1'b0, "R1 pfo in reset", pfo, 0);
    rst_n = 1'b1;
    step();
    chk(rst_pull == 1'b1 && pfo == 1'b0, "R1 after reset", {rst_pull, pfo}, 2);
  endtask

  task automatic t_power_return();
    int n = 0;
    int hi2 = 0;
    batt_on = 1'b0;
    for (int i = 1; i <= 200; i++) begin
      step();
      if (i == SYN) hi2 = pfo;
      if (i > SYN && !pfo) begin n = i; break; end
    end
    chk(hi2 == 1, "R9 pfo forced high", hi2, 1);
    chk(n == S + SYN, "R9 hold window end", n, S + SYN);
    pf_above = 1'b1;
    step();
    chk(pfo == 1'b0, "R10 not before latency", pfo, 0);
    step();
    chk(pfo == 1'b1, "R10 follows high", pfo, 1);
    pf_above = 1'b0;
    repeat (SYN) step();
    chk(pfo == 1'b0, "R10 follows low", pfo, 0);
    pf_above = 1'b1;
    supply_ok = 1'b1;
    wait_release(n);
    chk(n == S + SYN, "R3 power-up release", n, S + SYN);
  endtask

  task automatic t_supply_dip();
    int n;
    bit held = 1'b1;
    supply_ok = 1'b0;
    repeat (SYN) step();
    chk(rst_pull == 1'b0, "R2 not before latency", rst_pull, 0);
    step();
    chk(rst_pull == 1'b1, "R2 pulled after latency", rst_pull, 1);
    for (int i = 0; i < 30; i++) begin
      step();
      if (!rst_pull) held = 1'b0;
    end
    chk(held, "R2 held while low", held, 1);
    supply_ok = 1'b1;
    wait_release(n);
    chk(n == S + SYN, "R3 release after dip", n, S + SYN);
  endtask

  task automatic t_manual_long();
    int n;
    mr_pulse(W + 6);
    chk(rst_pull == 1'b1, "R4 held during press", rst_pull, 1);
    wait_release(n);
    chk(n == S + SYN + 1, "R4 long press release", n, S + SYN + 1);
    repeat (5) step();
    mr_pulse(W);
    wait_release(n);
    chk(n == S + SYN + 1, "R4 exact width qualifies", n, S + SYN + 1);
  endtask

  task automatic t_manual_short();
    bit quiet = 1'b1;
    repeat (5) step();
    mr_pulse(W - 1);
    for (int i = 0; i < S + 10; i++) begin
      step();
      if (rst_pull) quiet = 1'b0;
    end
    chk(quiet, "R5 width MIN_W-1 ignored", rst_pull, 0);
    quiet = 1'b1;
    mr_pulse(1);
    for (int i = 0; i < S + 10; i++) begin
      step();
      if (rst_pull) quiet = 1'b0;
    end
    chk(quiet, "R5 single sample ignored", rst_pull, 0);
  endtask

  task automatic t_retrigger();
    int n;
    mr_pulse(W + 2);
    repeat (10) step();
    chk(rst_pull == 1'b1, "R6 first stretch running", rst_pull, 1);
    mr_pulse(W + 2);
    wait_release(n);
    chk(n == S + SYN + 1, "R6 restart from second", n, S + SYN + 1);
  endtask

  task automatic t_short_inside();
    int n = 999;
    repeat (5) step();
    mr_pulse(W + 2);
    for (int i = 1; i <= 200; i++) begin
      step();
      if (i == 5) mr_n = 1'b0;
      if (i == 7) mr_n = 1'b1;
      if (i > 3 && !rst_pull) begin n = i; break; end
    end
    chk(n == S + SYN + 1, "R7 short pulse inside stretch", n, S + SYN + 1);
  endtask

  task automatic t_battery();
    int n = 0;
    int hi2 = 0;
    repeat (5) step();
    chk(pfo == 1'b1, "R10 tracking before battery", pfo, 1);
    batt_on = 1'b1;
    step();
    chk(pfo == 1'b1, "R8 not before latency", pfo, 1);
    step();
    chk(pfo == 1'b0, "R8 low on battery", pfo, 0);
    repeat (10) step();
    chk(pfo == 1'b0, "R8 stays low", pfo, 0);
    pf_above = 1'b0;
    batt_on = 1'b0;
    for (int i = 1; i <= 200; i++) begin
      step();
      if (i == SYN) hi2 = pfo;
      if (i > SYN && !pfo) begin n = i; break; end
    end
    chk(hi2 == 1, "R9 forced high again", hi2, 1);
    chk(n == S + SYN, "R9 second hold window", n, S + SYN);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_power_return();
    t_supply_dip();
    t_manual_long();
    t_manual_short();
    t_retrigger();
    t_short_inside();
    t_battery();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule